// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor DMA

This block feeds a transmit MAC from memory. Software builds a ring of descriptors. Each descriptor points at one buffer fragment, and a frame may be spread over several consecutive descriptors. The engine fetches each descriptor, reads the fragment's bytes a word at a time, and streams them out one byte per handshake. The stream carries a start-of-frame marker on the first byte of a frame and an end-of-frame marker on the final byte of a frame. A per-fragment flag in the descriptor marks the fragment that closes a frame.

For every fragment it finishes, the engine writes one 32-bit status word into a second array. That array has the same number of entries as the descriptor ring, and status entry i belongs to descriptor i. After the status write is accepted, the engine advances its consume index. Software hands over work by moving the produce index. The engine works while the two indices differ and the enable bit is set.

Top module: `txgather_dma`

## Requirements
- R1: Register map, selected by `reg_addr`. 0 is control, with enable in bit 0. 1 is the descriptor base. 2 is the status base. 3 is the last ring index (entry count minus 1). 4 is the produce index. 5 is the consume index, which is read-only: writes to it have no effect. All registers read as zero after reset.
- R2: Bits [1:0] of both base registers always read as zero. Every memory access uses a word-aligned address.
- R3: Descriptor i occupies two words. The word at desc_base + 8*i is the buffer byte address. The word at desc_base + 8*i + 4 holds the fragment length minus one in bits [10:0] and the frame-closing flag in bit 30.
- R4: The engine processes descriptors while consume differs from produce. Consume wraps to 0 after it reaches the last ring index.
- R5: Fragment bytes leave in ascending address order. Within a 32-bit word the byte at the lowest address sits in bits [7:0]. Buffers may start and end at any byte offset.
- R6: `out_sof` is high on the first byte of the first fragment after reset, and on the first byte of the first fragment after a fragment that closed a frame. It is low on all other bytes.
- R7: `out_eof` is high only on the final byte of a fragment whose closing flag is set. A one-byte closing fragment carries both markers.
- R8: After a fragment's last byte, the engine writes status_base + 4*i. Bit 31 is an error flag, set when any read for that fragment returned `mem_rerr`. Bit 30 echoes the closing flag. Bits [10:0] echo the length field. The consume index advances only once this write is granted.
- R9: While enable is clear, no new descriptor is started and no memory request is issued. Clearing enable during a fragment lets that fragment and its status write finish.
- R10: `mem_req` holds its address, data and direction until `mem_gnt`. `out_valid` holds the byte and both markers until `out_ready`. Read data is taken only from the cycle where `mem_rvalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write (status) |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Status word for writes |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| mem_rerr | input | 1 | Read returned an error |
| out_valid | output | 1 | Byte available |
| out_data | output | 8 | Byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Final byte of a frame |
| out_ready | input | 1 | Sink accepts the byte |

## Verification
The bench builds the engine with a 3-bit index, so the ring is at most eight entries. It programs the last index to 4, which lets a few descriptors carry the consume index across the wrap from 4 back to 0. The address width stays at 32, so buffers can sit at odd offsets and a fragment of up to twenty bytes crosses several word boundaries. A fragment placed in a bus-error region brings the status error bit into play. Periodic grant and ready stalls exercise the holding rules. Dropping enable in the middle of that long fragment shows that the engine halts at the fragment boundary.

// File: rtl/txg_pkg.sv
// Shared types and constants for the scatter-gather transmit engine.
// Assumes 32-bit memory words and little-endian byte lanes.
package txg_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_D0_REQ, S_D0_WAIT, S_D1_REQ, S_D1_WAIT,
        S_BUF_REQ, S_BUF_WAIT, S_SEND, S_STAT
    } txg_state_e;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_DBASE = 3'd1;
    localparam logic [2:0] RA_SBASE = 3'd2;
    localparam logic [2:0] RA_LAST  = 3'd3;
    localparam logic [2:0] RA_PROD  = 3'd4;
    localparam logic [2:0] RA_CONS  = 3'd5;

    localparam int DESC_CLOSE_BIT = 30;
    localparam int ST_ERR_BIT     = 31;
    localparam int ST_CLOSE_BIT   = 30;
endpackage

// File: rtl/txg_regs.sv
// Register file for the transmit engine: enable, ring bases, ring size and
// the produce/consume indices. Consume is advanced only by the engine.
// Assumes software keeps produce within 0..ring_last.
module txg_regs
    import txg_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             adv,
    output logic             enable,
    output logic [AW-1:0]    desc_base,
    output logic [AW-1:0]    stat_base,
    output logic [IDX_W-1:0] ring_last,
    output logic [IDX_W-1:0] produce,
    output logic [IDX_W-1:0] consume,
    output logic             pending
);
    // software-owned registers, bases forced to word alignment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable    <= 1'b0;
            desc_base <= '0;
            stat_base <= '0;
            ring_last <= '0;
            produce   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CTRL:  enable    <= reg_wdata[0];
                RA_DBASE: desc_base <= {reg_wdata[AW-1:2], 2'b00};
                RA_SBASE: stat_base <= {reg_wdata[AW-1:2], 2'b00};
                RA_LAST:  ring_last <= reg_wdata[IDX_W-1:0];
                RA_PROD:  produce   <= reg_wdata[IDX_W-1:0];
                default:  ;
            endcase
        end
    end

    // engine-owned consume index with wrap at ring_last
    always_ff @(posedge clk) begin
        if (!rst_n)
            consume <= '0;
        else if (adv)
            consume <= (consume == ring_last) ? '0 : consume + 1'b1;
    end

    // work is outstanding when the indices differ
    assign pending = (consume != produce);

    // read-back multiplexer
    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = {31'd0, enable};
            RA_DBASE: reg_rdata = 32'(desc_base);
            RA_SBASE: reg_rdata = 32'(stat_base);
            RA_LAST:  reg_rdata = 32'(ring_last);
            RA_PROD:  reg_rdata = 32'(produce);
            RA_CONS:  reg_rdata = 32'(consume);
            default:  reg_rdata = 32'd0;
        endcase
    end

    // R8: consume moves only in the cycle after a granted status write
    a_r8_consume_after_status: assert property (@(posedge clk) disable iff (!rst_n)
        (consume != $past(consume)) |-> $past(adv));
    // R4: an advance from the last ring index lands on zero
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && consume == ring_last && !(reg_we && reg_addr == RA_LAST)) |=> (consume == '0));
endmodule

// File: rtl/txg_lane.sv
// Byte lane picker: selects one byte of a 32-bit little-endian word.
// Pure combinational; the offset is the low two bits of the byte address.
module txg_lane #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0]         word,
    input  logic [$clog2(LANES)-1:0]   offset,
    output logic [7:0]                 byte_o
);
    logic [7:0] lane [LANES];

    // split the word into its byte lanes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word[8*g +: 8];
    end

    // choose the lane addressed by the offset
    assign byte_o = lane[offset];
endmodule

// File: rtl/txg_seq.sv
// Descriptor walker: fetches two descriptor words, reads the fragment one
// word at a time, streams its bytes and writes the status word.
// Assumes one outstanding read; read data arrives with mem_rvalid after grant.
module txg_seq
    import txg_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int AW     = 32,
    parameter int SIZE_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pending,
    input  logic [AW-1:0]    desc_base,
    input  logic [AW-1:0]    stat_base,
    input  logic [IDX_W-1:0] consume,
    output logic             adv,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_gnt,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_rerr,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    input  logic             out_ready
);
    localparam int PAD_D = AW - IDX_W - 3;
    localparam int PAD_S = AW - IDX_W - 2;

    txg_state_e        state;
    logic [AW-1:0]     cur;
    logic [SIZE_W-1:0] remain;
    logic [SIZE_W-1:0] size_q;
    logic              close_q;
    logic              err_q;
    logic              frame_first;
    logic              frag_start;
    logic [31:0]       word_q;
    logic [AW-1:0]     d_addr;
    logic [AW-1:0]     s_addr;

    assign d_addr = desc_base + {{PAD_D{1'b0}}, consume, 3'b000};
    assign s_addr = stat_base + {{PAD_S{1'b0}}, consume, 2'b00};

    // main sequencing of descriptor, buffer and status phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            cur         <= '0;
            remain      <= '0;
            size_q      <= '0;
            close_q     <= 1'b0;
            err_q       <= 1'b0;
            frame_first <= 1'b1;
            frag_start  <= 1'b0;
            word_q      <= '0;
        end else begin
            case (state)
                S_IDLE: if (enable && pending) begin
                    err_q <= 1'b0;
                    state <= S_D0_REQ;
                end
                S_D0_REQ: if (mem_gnt) state <= S_D0_WAIT;
                S_D0_WAIT: if (mem_rvalid) begin
                    cur   <= mem_rdata[AW-1:0];
                    err_q <= err_q | mem_rerr;
                    state <= S_D1_REQ;
                end
                S_D1_REQ: if (mem_gnt) state <= S_D1_WAIT;
                S_D1_WAIT: if (mem_rvalid) begin
                    remain     <= mem_rdata[SIZE_W-1:0];
                    size_q     <= mem_rdata[SIZE_W-1:0];
                    close_q    <= mem_rdata[DESC_CLOSE_BIT];
                    err_q      <= err_q | mem_rerr;
                    frag_start <= 1'b1;
                    state      <= S_BUF_REQ;
                end
                S_BUF_REQ: if (mem_gnt) state <= S_BUF_WAIT;
                S_BUF_WAIT: if (mem_rvalid) begin
                    word_q <= mem_rdata;
                    err_q  <= err_q | mem_rerr;
                    state  <= S_SEND;
                end
                S_SEND: if (out_ready) begin
                    frag_start <= 1'b0;
                    if (remain == '0) begin
                        state <= S_STAT;
                    end else begin
                        cur    <= cur + 1'b1;
                        remain <= remain - 1'b1;
                        if (cur[1:0] == 2'b11) state <= S_BUF_REQ;
                    end
                end
                S_STAT: if (mem_gnt) begin
                    frame_first <= close_q;
                    state       <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // memory request decode per phase
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_D0_REQ: begin mem_req = 1'b1; mem_addr = d_addr; end
            S_D1_REQ: begin mem_req = 1'b1; mem_addr = d_addr + AW'(4); end
            S_BUF_REQ: begin mem_req = 1'b1; mem_addr = {cur[AW-1:2], 2'b00}; end
            S_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = s_addr;
                mem_wdata = '0;
                mem_wdata[ST_ERR_BIT]   = err_q;
                mem_wdata[ST_CLOSE_BIT] = close_q;
                mem_wdata[SIZE_W-1:0]   = size_q;
            end
            default: ;
        endcase
    end

    txg_lane #(.LANES(4)) u_lane (
        .word   (word_q),
        .offset (cur[1:0]),
        .byte_o (out_data)
    );

    // stream side markers and ring advance strobe
    assign out_valid = (state == S_SEND);
    assign out_sof   = out_valid && frame_first && frag_start;
    assign out_eof   = out_valid && close_q && (remain == '0);
    assign adv       = (state == S_STAT) && mem_gnt;

    // R10: a pending memory request keeps its address and direction
    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R10: an unaccepted byte stays on the stream unchanged
    a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));
    // R2: every memory access is word aligned
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    // R6: start marker appears on at most one byte of a fragment
    a_r6_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_sof) |=> !out_sof);
    // R9: with enable low and nothing in flight, no request is raised
    a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !mem_req && !out_valid && state == S_IDLE) |=> !mem_req);
endmodule

// File: rtl/txgather_dma.sv
// Top of the scatter-gather transmit DMA: register file plus descriptor walker.
// Assumes AW > IDX_W + 3 and a single-outstanding-read memory port.
module txgather_dma #(
    parameter int IDX_W  = 8,
    parameter int AW     = 32,
    parameter int SIZE_W = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_rerr,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_sof,
    output logic          out_eof,
    input  logic          out_ready
);
    logic             enable;
    logic             pending;
    logic             adv;
    logic [AW-1:0]    desc_base;
    logic [AW-1:0]    stat_base;
    logic [IDX_W-1:0] ring_last;
    logic [IDX_W-1:0] produce;
    logic [IDX_W-1:0] consume;

    txg_regs #(.IDX_W(IDX_W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .adv       (adv),
        .enable    (enable),
        .desc_base (desc_base),
        .stat_base (stat_base),
        .ring_last (ring_last),
        .produce   (produce),
        .consume   (consume),
        .pending   (pending)
    );

    txg_seq #(.IDX_W(IDX_W), .AW(AW), .SIZE_W(SIZE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .pending    (pending),
        .desc_base  (desc_base),
        .stat_base  (stat_base),
        .consume    (consume),
        .adv        (adv),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_rerr   (mem_rerr),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_sof    (out_sof),
        .out_eof    (out_eof),
        .out_ready  (out_ready)
    );
endmodule

// File: tb/txgather_dma_tb_top.sv
// Bench: behavioural memory, expected-byte and expected-status queues built
// from the descriptors, compared at every transfer.
module txgather_dma_tb_top;
    localparam int IDX_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0, mem_rerr = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid, out_sof, out_eof;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;

    txgather_dma #(.IDX_W(IDX_W)) dut_i (.*);

    always #10 clk = ~clk;

    int total = 0, bad = 0, cyc = 0, req_seen = 0;
    logic [31:0] mem [int unsigned];
    logic [9:0]  exp_b [$];
    logic [63:0] exp_s [$];
    logic [31:0] dbase, sbase;
    bit first_m = 1'b1;
    bit rd_pend = 1'b0;
    logic [31:0] rd_addr;
    int rd_wait;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rdw(logic [31:0] a);
        return mem.exists(a >> 2) ? mem[a >> 2] : 32'd0;
    endfunction

    function automatic bit in_err(logic [31:0] a);
        return (a >= 32'h3000) && (a < 32'h3100);
    endfunction

    task automatic set_byte(logic [31:0] a, logic [7:0] v);
        logic [31:0] w;
        w = rdw(a);
        w[8*a[1:0] +: 8] = v;
        mem[a >> 2] = w;
    endtask

    task automatic set_desc(int idx, logic [31:0] buf_a, int n, bit close);
        logic [31:0] w1;
        mem[(dbase + 8*idx) >> 2] = buf_a;
        w1 = 32'(n - 1);
        w1[30] = close;
        w1[25] = 1'b1;
        mem[(dbase + 8*idx + 4) >> 2] = w1;
        for (int k = 0; k < n; k++) set_byte(buf_a + k, 8'((buf_a + k) * 7 + 3));
    endtask

    task automatic model_frag(int idx);
        logic [31:0] w0, w1, st;
        int n;
        bit close, err;
        w0 = rdw(dbase + 8*idx);
        w1 = rdw(dbase + 8*idx + 4);
        n = int'(w1[10:0]) + 1;
        close = w1[30];
        err = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic [31:0] a;
            logic [7:0] b;
            a = w0 + k;
            b = rdw(a) >> (8 * a[1:0]);
            if (in_err(a)) err = 1'b1;
            exp_b.push_back({b, first_m && k == 0, close && k == n - 1});
        end
        st = {err, close, 19'd0, w1[10:0]};
        exp_s.push_back({sbase + 32'(4*idx), st});
        first_m = close;
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // memory, stream sink and comparison, all driven at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (rst_n) begin
            mem_rvalid = 1'b0;
            mem_rerr = 1'b0;
            if (rd_pend) begin
                if (rd_wait == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = rdw(rd_addr);
                    mem_rerr = in_err(rd_addr);
                    rd_pend = 1'b0;
                end else rd_wait--;
            end
            if (mem_req) req_seen++;
            mem_gnt = mem_req && (cyc % 3 != 1);
            if (mem_gnt) begin
                if (mem_we) begin
                    if (exp_s.size() == 0)
                        chk(0, "R8 unexpected status", {mem_addr, mem_wdata}, 0);
                    else begin
                        logic [63:0] e;
                        e = exp_s.pop_front();
                        chk({mem_addr, mem_wdata} == e, "R8 status write", {mem_addr, mem_wdata}, e);
                    end
                end else begin
                    rd_pend = 1'b1;
                    rd_addr = mem_addr;
                    rd_wait = cyc % 3;
                end
            end
            out_ready = (cyc % 4 != 2);
            if (out_valid && out_ready) begin
                if (exp_b.size() == 0)
                    chk(0, "R9 unexpected byte", {out_data, out_sof, out_eof}, 0);
                else begin
                    logic [9:0] e;
                    e = exp_b.pop_front();
                    chk(out_data == e[9:2], "R5 byte order", out_data, e[9:2]);
                    chk(out_sof == e[1], "R6 start marker", out_sof, e[1]);
                    chk(out_eof == e[0], "R7 end marker", out_eof, e[0]);
                end
            end
        end
    end

    initial begin
        logic [31:0] d;
        int snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        for (int a = 0; a < 6; a++) begin
            rd_reg(3'(a), d);
            chk(d == 0, "R1 reset register", d, 0);
        end
        chk(!mem_req && !out_valid, "R1 idle after reset", {mem_req, out_valid}, 0);

        // R2 base alignment, R1 consume read-only
        wr_reg(3'd1, 32'h1003);
        rd_reg(3'd1, d);
        chk(d == 32'h1000, "R2 descriptor base low bits", d, 32'h1000);
        wr_reg(3'd2, 32'h2002);
        rd_reg(3'd2, d);
        chk(d == 32'h2000, "R2 status base low bits", d, 32'h2000);
        dbase = 32'h1000; sbase = 32'h2000;
        wr_reg(3'd3, 32'd4);
        wr_reg(3'd5, 32'd3);
        rd_reg(3'd5, d);
        chk(d == 0, "R1 consume write ignored", d, 0);

        // R3 descriptors: single-fragment frame, then a three-fragment frame
        set_desc(0, 32'h4000, 5, 1'b1);
        set_desc(1, 32'h4101, 6, 1'b0);
        set_desc(2, 32'h4203, 1, 1'b0);
        set_desc(3, 32'h4302, 9, 1'b1);
        wr_reg(3'd4, 32'd4);
        snap = req_seen;
        repeat (30) @(negedge clk);
        chk(req_seen == snap, "R9 no request while disabled", req_seen - snap, 0);
        rd_reg(3'd5, d);
        chk(d == 0, "R9 consume held while disabled", d, 0);
        for (int i = 0; i < 4; i++) model_frag(i);
        wr_reg(3'd0, 32'd1);
        for (int t = 0; t < 3000 && (exp_s.size() != 0); t++) @(negedge clk);
        repeat (5) @(negedge clk);
        rd_reg(3'd5, d);
        chk(d == 4, "R4 consume reaches produce", d, 4);
        chk(exp_b.size() == 0, "R10 all bytes delivered", exp_b.size(), 0);

        // error fragment at last index, then wrap; stop midway through it
        set_desc(4, 32'h3001, 20, 1'b1);
        set_desc(0, 32'h4400, 1, 1'b1);
        set_desc(1, 32'h4507, 3, 1'b1);
        model_frag(4);
        wr_reg(3'd4, 32'd2);
        for (int t = 0; t < 3000 && exp_b.size() > 15; t++) @(negedge clk);
        wr_reg(3'd0, 32'd0);
        repeat (40) @(negedge clk);
        snap = req_seen;
        repeat (30) @(negedge clk);
        chk(req_seen == snap, "R9 halted at fragment boundary", req_seen - snap, 0);
        rd_reg(3'd5, d);
        chk(d == 0, "R4 consume wrapped to zero", d, 0);
        chk(exp_s.size() == 0 && exp_b.size() == 0, "R9 fragment finished before halt",
            exp_s.size() + exp_b.size(), 0);

        // resume: one-byte frame (both markers) and an unaligned frame
        model_frag(0);
        model_frag(1);
        wr_reg(3'd0, 32'd1);
        for (int t = 0; t < 3000 && (exp_s.size() != 0); t++) @(negedge clk);
        repeat (5) @(negedge clk);
        rd_reg(3'd5, d);
        chk(d == 2, "R4 resumed to produce", d, 2);
        chk(exp_b.size() == 0, "R10 all bytes delivered after resume", exp_b.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule